// File: doc/BRIEF.md
# Serial Slow-Control Register Slave

This block lets an external master reach a bank of 32-bit configuration registers over a synchronous serial link. The master supplies the link clock and a single inbound data line. The slave returns read data on its own outbound data line. Every bit is sampled and driven on the rising edge of the master's clock, which nominally runs at 20 MHz.

A frame opens with a four-bit start pattern. A one-bit command follows, then a 16-bit register address. After that come 32 data bits, which travel inward on a write and outward on a read. Sixteen general registers sit at word-aligned addresses from 0x0000 up to 0x003C. A fixed test word lives at 0xFFFC, so the master can check the link without touching any configuration state. When a write frame completes, the slave raises a one-cycle strobe that carries the address and data, so that nearby logic can react to it.

Top module: `sc_reg_slave`

## Requirements
- R1: While idle, the slave leaves idle only after it has sampled the bits 1,0,1,0 on `sdi` on consecutive rising edges (first bit first). No other bit sequence moves it out of idle.
- R2: The edge after the start pattern samples the command bit, where 1 means read and 0 means write. The next 16 edges sample the address, most significant bit first.
- R3: On a read, `sdo` shows data bit 31 from the edge that samples the last address bit onward. Each following edge presents the next lower bit, until all 32 bits have been sent.
- R4: `sdo` is 0 whenever no read data is being shifted out, and that includes the cycle after the 32nd read bit.
- R5: On a write, the 32 data bits following the address are sampled most significant bit first. They are stored into the general register when the address is a multiple of 4 in the range 0x0000 to 0x003C.
- R6: A read of address 0xFFFC returns 0x12345678. A write to 0xFFFC changes nothing that any later read returns.
- R7: A write to an address that is not mapped or not aligned changes no register. A read of such an address returns 0.
- R8: For exactly one cycle, starting at the edge after the one that samples the 32nd write data bit, `wr_stb` is 1 while `wr_addr` and `wr_data` hold the address and data of the frame. This happens for every completed write frame, whether or not the address is mapped.
- R9: When `rst_n` is 0 at a rising edge, all registers are cleared to 0, the slave goes idle, and `sdo` and `wr_stb` go to 0.
- R10: Once the 32nd data bit has been handled, the slave is idle again. It accepts a start pattern that begins on the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial link clock driven by the master |
| rst_n | input | 1 | Synchronous active-low reset |
| sdi | input | 1 | Inbound serial data from the master |
| sdo | output | 1 | Outbound serial read data, low when unused |
| wr_stb | output | 1 | One-cycle pulse after a completed write frame |
| wr_addr | output | 16 | Address of the completed write frame |
| wr_data | output | 32 | Data of the completed write frame |

## Verification
The assertions rely on the master holding `rst_n` low for at least one edge before it starts framing, and on every frame, once started, running to its full length on consecutive clock edges. The start-pattern check also needs the `sdi` history back to the first post-reset edge to be meaningful. The stimulus keeps within these limits. It drives `sdi` only on falling edges and sends whole frames, separated either by idle zeros or by nothing at all. Its noise bursts contain no 1010 run, so every frame the slave sees is one the scoreboard expects.

// File: rtl/sc_pkg.sv
// Package sc_pkg: shared types for the serial slow-control slave.
// Assumes nothing beyond IEEE 1800-2017 package semantics.
package sc_pkg;

    // Frame phases of the serial protocol
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CMD  = 3'd1,
        ST_ADDR = 3'd2,
        ST_RD   = 3'd3,
        ST_WR   = 3'd4
    } sc_state_e;

endpackage

// File: rtl/sc_addr_decode.sv
// Module sc_addr_decode: maps a byte address onto the general register bank.
// Assumes NREG is a power of two and AW > log2(NREG) + 2.
module sc_addr_decode #(
    parameter int AW   = 16,
    parameter int NREG = 16,
    localparam int IW  = $clog2(NREG)
) (
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [IW-1:0] idx
);

    // Word-aligned and below NREG*4 means a general register
    always_comb begin
        hit = (addr[1:0] == 2'b00) && (addr[AW-1:IW+2] == '0);
        idx = addr[IW+1:2];
    end

endmodule

// File: rtl/sc_reg_bank.sv
// Module sc_reg_bank: general configuration registers plus a fixed test word.
// Assumes wr_en is a single-cycle pulse; reads are purely combinational.
module sc_reg_bank #(
    parameter int          AW        = 16,
    parameter int          DW        = 32,
    parameter int          NREG      = 16,
    parameter logic [15:0] TEST_ADDR = 16'hFFFC,
    parameter logic [31:0] TEST_VAL  = 32'h1234_5678,
    localparam int         IW        = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] regs [NREG];
    logic          wr_hit, rd_hit;
    logic [IW-1:0] wr_idx, rd_idx;

    sc_addr_decode #(.AW(AW), .NREG(NREG)) i_wr_dec (
        .addr (wr_addr),
        .hit  (wr_hit),
        .idx  (wr_idx)
    );

    sc_addr_decode #(.AW(AW), .NREG(NREG)) i_rd_dec (
        .addr (rd_addr),
        .hit  (rd_hit),
        .idx  (rd_idx)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Store one general register on a mapped write strobe
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_en && wr_hit && (wr_idx == IW'(g))) begin
                regs[g] <= wr_data;
            end
        end

        // R7: a register not targeted by a mapped write keeps its value
        // R7
        bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_hit && (wr_idx == IW'(g))) |=> $stable(regs[g]));
    end

    // Select test word, general register, or zero for reads
    always_comb begin
        if (rd_addr == TEST_ADDR[AW-1:0]) begin
            rd_data = TEST_VAL[DW-1:0];
        end else if (rd_hit) begin
            rd_data = regs[rd_idx];
        end else begin
            rd_data = '0;
        end
    end

    // R5
    bank_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hit) |=> (regs[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/sc_frame_ctl.sv
// Module sc_frame_ctl: serial framing, command decode and data shifting.
// Assumes sdi is synchronous to clk and frames run without clock gaps.
module sc_frame_ctl
    import sc_pkg::*;
#(
    parameter int         AW    = 16,
    parameter int         DW    = 32,
    parameter logic [3:0] START = 4'b1010,
    localparam int        CMAX  = (DW > AW) ? DW : AW,
    localparam int        CW    = $clog2(CMAX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sdi,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data,
    output logic          sdo,
    output logic          wr_stb,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);

    sc_state_e     state;
    logic [3:0]    hist;
    logic [CW-1:0] cnt;
    logic          is_rd;
    logic [AW-1:0] addr_sh;
    logic [DW-1:0] tx_sh;
    logic [DW-1:0] rx_sh;

    // Full address as it stands once the current bit is included
    always_comb rd_addr = {addr_sh[AW-2:0], sdi};

    // Outbound line carries data only while a read is shifting
    always_comb sdo = (state == ST_RD) && tx_sh[DW-1];

    // Frame sequencer: start detect, command, address, data phases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            hist    <= '0;
            cnt     <= '0;
            is_rd   <= 1'b0;
            addr_sh <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if ({hist[2:0], sdi} == START) begin
                        state <= ST_CMD;
                        hist  <= '0;
                    end else begin
                        hist <= {hist[2:0], sdi};
                    end
                end
                ST_CMD: begin
                    is_rd <= sdi;
                    cnt   <= '0;
                    state <= ST_ADDR;
                end
                ST_ADDR: begin
                    addr_sh <= rd_addr;
                    if (cnt == CW'(AW - 1)) begin
                        cnt <= '0;
                        if (is_rd) begin
                            tx_sh <= rd_data;
                            state <= ST_RD;
                        end else begin
                            state <= ST_WR;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_RD: begin
                    tx_sh <= {tx_sh[DW-2:0], 1'b0};
                    if (cnt == CW'(DW - 1)) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WR: begin
                    rx_sh <= {rx_sh[DW-2:0], sdi};
                    if (cnt == CW'(DW - 1)) begin
                        cnt     <= '0;
                        wr_stb  <= 1'b1;
                        wr_addr <= addr_sh;
                        wr_data <= {rx_sh[DW-2:0], sdi};
                        state   <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1
    start_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD) |-> (($past(state) == ST_IDLE) && ($past(sdi) == START[0])
            && ($past(sdi, 2) == START[1]) && ($past(sdi, 3) == START[2])
            && ($past(sdi, 4) == START[3])));

    // R8
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R10
    frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (state == ST_IDLE));

endmodule

// File: rtl/sc_reg_slave.sv
// Module sc_reg_slave: top of the serial slow-control register slave.
// Assumes clk is the master's link clock and rst_n is synchronous to it.
module sc_reg_slave #(
    parameter int          AW        = 16,
    parameter int          DW        = 32,
    parameter int          NREG      = 16,
    parameter logic [15:0] TEST_ADDR = 16'hFFFC,
    parameter logic [31:0] TEST_VAL  = 32'h1234_5678
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sdi,
    output logic          sdo,
    output logic          wr_stb,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);

    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;

    sc_frame_ctl #(.AW(AW), .DW(DW)) i_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .sdi     (sdi),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .sdo     (sdo),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    sc_reg_bank #(
        .AW(AW), .DW(DW), .NREG(NREG), .TEST_ADDR(TEST_ADDR), .TEST_VAL(TEST_VAL)
    ) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!wr_stb && !sdo));

endmodule

// File: tb/test_sc_reg_slave.sv
// Bench test_sc_reg_slave: scoreboard bench for the serial register slave.
// Driver tasks queue expected reads and strobes; monitors compare them.
module test_sc_reg_slave;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo;
    logic        wr_stb;
    logic [15:0] wr_addr;
    logic [31:0] wr_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] mdl [16];
    logic [31:0] rq [$];
    logic [47:0] wq [$];
    event        rd_go;

    sc_reg_slave i_sc_reg_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .sdi     (sdi),
        .sdo     (sdo),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    // 200 MHz clock
    always #2.5 clk = ~clk;

    // Record a single comparison
    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Model read value of an address
    function automatic logic [31:0] model_rd(input logic [15:0] a);
        if (a == 16'hFFFC) return 32'h1234_5678;
        if (a[1:0] == 2'b00 && a < 16'h0040) return mdl[a[5:2]];
        return 32'h0;
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk);
        sdi = b;
    endtask

    task automatic send_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    endtask

    // Drive a write frame, gap idle bits after it
    task automatic do_write(input logic [15:0] a, input logic [31:0] d, input int gap);
        wq.push_back({a, d});
        if (a[1:0] == 2'b00 && a < 16'h0040) mdl[a[5:2]] = d;
        send_start();
        send_bit(1'b0);
        for (int i = 15; i >= 0; i--) send_bit(a[i]);
        for (int i = 31; i >= 0; i--) send_bit(d[i]);
        for (int i = 0; i < gap; i++) send_bit(1'b0);
    endtask

    // Drive a read frame and check the line is low afterwards
    task automatic do_read(input logic [15:0] a);
        rq.push_back(model_rd(a));
        send_start();
        send_bit(1'b1);
        for (int i = 15; i >= 0; i--) send_bit(a[i]);
        -> rd_go;
        for (int i = 0; i < 34; i++) send_bit(1'b0);
        check("R4 sdo after read", {47'h0, sdo}, 48'h0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sdi = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 sdo in reset", {47'h0, sdo}, 48'h0);
        check("R9 wr_stb in reset", {47'h0, wr_stb}, 48'h0);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) mdl[i] = 32'h0;
    endtask

    // Monitor: collect 32 outbound bits per read and compare with queue
    initial begin
        forever begin
            logic [31:0] got;
            @(rd_go);
            for (int i = 31; i >= 0; i--) begin
                @(negedge clk);
                got[i] = sdo;
            end
            if (rq.size() == 0) begin
                check("R3 unexpected read", {16'h0, got}, 48'h0);
            end else begin
                check("R3 read data", {16'h0, got}, {16'h0, rq.pop_front()});
            end
        end
    end

    // Monitor: compare each write strobe with the queued frame
    always @(negedge clk) begin
        if (rst_n && wr_stb) begin
            if (wq.size() == 0) begin
                check("R8 spurious strobe", {wr_addr, wr_data}, 48'h0);
            end else begin
                check("R8 strobe addr/data", {wr_addr, wr_data}, wq.pop_front());
            end
        end
    end

    // Watchdog
    initial begin
        #750000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Stimulus
    initial begin
        do_reset();
        // R9: registers are zero after reset
        do_read(16'h0000);
        do_read(16'h003C);
        // R5, R2: fill every general register, then read them back
        for (int i = 0; i < 16; i++) do_write(16'(i * 4), 32'hA5C3_0000 ^ (32'(i) * 32'h0101_1011), 3);
        for (int i = 0; i < 16; i++) do_read(16'(i * 4));
        // R6: test word, write ignored
        do_read(16'hFFFC);
        do_write(16'hFFFC, 32'hDEAD_FACE, 2);
        do_read(16'hFFFC);
        // R7: unmapped and misaligned writes ignored, reads give zero
        do_write(16'h0040, 32'hFFFF_FFFF, 2);
        do_write(16'h0006, 32'h0BAD_0BAD, 2);
        do_read(16'h0040);
        do_read(16'h0005);
        do_read(16'h0004);
        do_read(16'h8000);
        // R1: noise without a 1010 run leaves the slave idle
        send_bit(1); send_bit(1); send_bit(0); send_bit(0);
        send_bit(1); send_bit(1); send_bit(1); send_bit(0);
        send_bit(0); send_bit(1); send_bit(1); send_bit(0); send_bit(0);
        check("R1 no strobe after noise", {47'h0, wr_stb}, 48'h0);
        do_read(16'h0008);
        // R10: back-to-back frames with no idle gap
        do_write(16'h0010, 32'h8000_0001, 0);
        do_write(16'h0014, 32'h7FFF_FFFE, 0);
        do_read(16'h0010);
        do_read(16'h0014);
        // R9: reset clears stored values
        do_reset();
        do_read(16'h0010);
        do_read(16'h0020);
        repeat (4) @(negedge clk);
        check("R8 all strobes seen", 48'(wq.size()), 48'h0);
        check("R3 all reads seen", 48'(rq.size()), 48'h0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule